// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a bank of general-purpose input pins and turns pin activity into interrupt requests. Each pin is first brought into the clock domain by a two-stage synchronizer. It can then pass through an optional glitch filter that is paced by an external strobe. Finally a detector reports either a latched edge or a live level, with a polarity chosen per pin. Software sets the block up and services it through a simple bus with separate select and enable phases. It reads a status word that ignores the mask, and it acknowledges edge events by writing ones to a clear register.

A single interrupt line combines every status bit whose mask bit is clear. The block has no both-edges mode. Software gets the same effect by flipping a pin's polarity bit after each event. The detector keeps its previous-sample register running in every configuration, so a change of mode or polarity never produces a false edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register, the status word and `irq_o` are zero.
- R2: A write with `bus_sel`, `bus_en` and `bus_wr` high stores `bus_wdata` into the addressed register: enable at 0x30, mask at 0x34, trigger type at 0x38, polarity at 0x3C, debounce at 0x48. Reading these addresses returns the stored value. The clear register at 0x4C reads as zero.
- R3: Address 0x50 returns the qualified pin values. With debounce off, this is the pin input delayed by the two synchronizer flops.
- R4: With trigger type bit 1 (edge) and the enable bit set, polarity 1 latches a rising edge and polarity 0 latches a falling edge into that pin's bit of the status word at 0x40. The bit stays set after the pin returns to its inactive value.
- R5: Writing a word to 0x4C clears exactly the latched edge bits where the word has ones. Writing all ones clears every pending edge.
- R6: With trigger type bit 0 (level) and the enable bit set, the status bit is 1 while the qualified pin equals its polarity bit. A write to 0x4C does not change it.
- R7: With the enable bit 0, a pin sets no status bit in either mode.
- R8: `irq_o` is the OR of the status bits whose mask bit is 0. The mask does not change the status word. Writing all ones to the mask forces `irq_o` low and leaves the enable register unchanged.
- R9: With a pin's debounce bit set, a new input value is accepted only on the 4th consecutive `db_strobe_i` pulse during which it differs from the accepted value. Shorter pulses are discarded.
- R10: Changing the trigger type or polarity while the pins are still latches no edge.
- R11: Both-edge operation works by software: after a rising event, setting the pin's polarity to 0 and clearing the event lets the following falling edge latch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_en | input | 1 | Register bus access phase |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| pins_i | input | 32 | Asynchronous pin inputs |
| db_strobe_i | input | 1 | Debounce pacing strobe, one cycle per tick |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The in-RTL properties check the following on every cycle:
- a latched edge bit rises only where the enable bit was set and the qualified sample differed from the previous one;
- a clear write removes a bit unless a new edge arrives in the same cycle;
- the debounce output moves only on a strobe;
- an all-ones mask keeps the interrupt low;
- a register write lands on the next edge.

Some behaviour only the bench scenarios can show. These are polarity selection in each mode, across every pin; the exact number of strobes the filter needs; the immunity of level status to clear writes; and the software-driven both-edge sequence.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFF_ENABLE = 8'h30;
  localparam logic [7:0] OFF_MASK   = 8'h34;
  localparam logic [7:0] OFF_TYPE   = 8'h38;
  localparam logic [7:0] OFF_POL    = 8'h3C;
  localparam logic [7:0] OFF_STATUS = 8'h40;
  localparam logic [7:0] OFF_DEBNC  = 8'h48;
  localparam logic [7:0] OFF_CLEAR  = 8'h4C;
  localparam logic [7:0] OFF_PINVAL = 8'h50;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W     = 32,
  parameter int TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] db_en_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] qual_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [W-1:0] filt;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic          filt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else if (!db_en_i[i] || (raw_i[i] == filt_q)) begin
        cnt_q  <= '0;
        filt_q <= raw_i[i];
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          filt_q <= raw_i[i];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
    assign filt[i] = filt_q;
  end

  assign qual_o = (db_en_i & filt) | (~db_en_i & raw_i);

  // R9: while filtering, the accepted value only moves on a strobe
  assert_filter_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((filt ^ $past(filt)) & $past(db_en_i)) != '0) |-> $past(tick_i));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] edge_ev_o
);
  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] cur,
                                             input logic [W-1:0] old,
                                             input logic [W-1:0] pol);
    return (cur & ~old & pol) | (~cur & old & ~pol);
  endfunction

  function automatic logic [W-1:0] level_hits(input logic [W-1:0] cur,
                                              input logic [W-1:0] pol);
    return ~(cur ^ pol);
  endfunction

  logic [W-1:0] prev_q, latched_q;

  assign edge_ev_o = en_i & edge_mode_i & edge_hits(q_i, prev_q, pol_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      latched_q <= '0;
    end else begin
      prev_q    <= q_i;
      latched_q <= ((latched_q & ~clr_i) | edge_ev_o) & edge_mode_i;
    end
  end

  assign status_o = (latched_q & edge_mode_i) |
                    (en_i & ~edge_mode_i & level_hits(q_i, pol_i));

  // R10: a newly latched bit needs a real change of the sampled pin
  assert_edge_needs_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q & ~$past(latched_q) & ~$past(q_i ^ prev_q)) == '0);
  // R7: a newly latched bit needs the enable bit
  assert_edge_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q & ~$past(latched_q) & ~$past(en_i)) == '0);
  // R5: a cleared bit is gone unless a new edge came at once
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q & $past(clr_i) & ~$past(edge_ev_o)) == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W        = 32,
  parameter int DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_en,
  input  logic         bus_wr,
  input  logic [7:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pins_i,
  input  logic         db_strobe_i,
  output logic         irq_o
);
  logic [W-1:0] en_q, mask_q, type_q, pol_q, db_q;
  logic [W-1:0] sync_w, qual_w, status_w, edge_ev_w, clr_w;
  logic         wr_strobe;

  assign wr_strobe = bus_sel & bus_en & bus_wr;
  assign clr_w     = (wr_strobe && bus_addr == OFF_CLEAR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      db_q   <= '0;
    end else if (wr_strobe) begin
      case (bus_addr)
        OFF_ENABLE: en_q   <= bus_wdata;
        OFF_MASK:   mask_q <= bus_wdata;
        OFF_TYPE:   type_q <= bus_wdata;
        OFF_POL:    pol_q  <= bus_wdata;
        OFF_DEBNC:  db_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(sync_w)
  );

  gpio_debounce #(.W(W), .TICKS(DB_TICKS)) debounce_i (
    .clk(clk), .rst_n(rst_n), .tick_i(db_strobe_i), .db_en_i(db_q),
    .raw_i(sync_w), .qual_o(qual_w)
  );

  gpio_detect #(.W(W)) detect_i (
    .clk(clk), .rst_n(rst_n), .q_i(qual_w), .en_i(en_q),
    .edge_mode_i(type_q), .pol_i(pol_q), .clr_i(clr_w),
    .status_o(status_w), .edge_ev_o(edge_ev_w)
  );

  always_comb begin
    case (bus_addr)
      OFF_ENABLE: bus_rdata = en_q;
      OFF_MASK:   bus_rdata = mask_q;
      OFF_TYPE:   bus_rdata = type_q;
      OFF_POL:    bus_rdata = pol_q;
      OFF_STATUS: bus_rdata = status_w;
      OFF_DEBNC:  bus_rdata = db_q;
      OFF_PINVAL: bus_rdata = qual_w;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = |(status_w & ~mask_q);

  // R8: a full mask silences the output line
  assert_full_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o);
  // R2: an enable-register write is visible after the edge
  assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && bus_addr == OFF_ENABLE) |=> (en_q == $past(bus_wdata)));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic        db_strobe = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pins_i(pins), .db_strobe_i(db_strobe), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1'b1;
    @(negedge clk); bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic strobe;
    @(negedge clk); db_strobe = 1'b1;
    @(negedge clk); db_strobe = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    foreach (rd[i]) ;
    br(8'h30, rd); check("R1 enable", rd, 0);
    br(8'h34, rd); check("R1 mask", rd, 0);
    br(8'h38, rd); check("R1 type", rd, 0);
    br(8'h3C, rd); check("R1 polarity", rd, 0);
    br(8'h48, rd); check("R1 debounce", rd, 0);
    br(8'h40, rd); check("R1 status", rd, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 register readback
    bw(8'h30, 32'hA5A5_0F0F); br(8'h30, rd); check("R2 enable", rd, 32'hA5A5_0F0F);
    bw(8'h34, 32'h1234_5678); br(8'h34, rd); check("R2 mask", rd, 32'h1234_5678);
    bw(8'h38, 32'h0F0F_F0F0); br(8'h38, rd); check("R2 type", rd, 32'h0F0F_F0F0);
    bw(8'h3C, 32'hDEAD_BEEF); br(8'h3C, rd); check("R2 polarity", rd, 32'hDEAD_BEEF);
    bw(8'h48, 32'h8000_0001); br(8'h48, rd); check("R2 debounce", rd, 32'h8000_0001);
    br(8'h4C, rd); check("R2 clear reads zero", rd, 0);
    bw(8'h30, 0); bw(8'h34, 0); bw(8'h38, 0); bw(8'h3C, 0); bw(8'h48, 0);

    // R3 pin value register
    pins = 32'hC3A5_5A3C; wait_cyc(3);
    br(8'h50, rd); check("R3 pin value", rd, 32'hC3A5_5A3C);
    pins = 32'h0000_FFFF; wait_cyc(3);
    br(8'h50, rd); check("R3 pin value 2", rd, 32'h0000_FFFF);

    // R4/R6/R10 sweep: every pin, both modes, both polarities
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int pv = 0; pv < 2; pv++) begin
          logic [31:0] bit_p;
          bit_p = 32'd1 << p;
          pins = pv[0] ? 32'h0 : 32'hFFFF_FFFF;
          wait_cyc(3);
          bw(8'h38, m[0] ? 32'hFFFF_FFFF : 32'h0);
          bw(8'h3C, pv[0] ? 32'hFFFF_FFFF : 32'h0);
          bw(8'h30, bit_p);
          bw(8'h4C, 32'hFFFF_FFFF);
          wait_cyc(2);
          br(8'h40, rd); check("R10 no event after config", rd, 0);
          check("R10 irq quiet", {31'b0, irq}, 0);
          pins[p] = pv[0];
          wait_cyc(4);
          br(8'h40, rd); check(m[0] ? "R4 edge latched" : "R6 level active", rd, bit_p);
          check("R8 irq raised", {31'b0, irq}, 1);
          pins[p] = ~pv[0];
          wait_cyc(4);
          br(8'h40, rd); check(m[0] ? "R4 edge held" : "R6 level released", rd, m[0] ? bit_p : 0);
          if (m[0]) begin
            bw(8'h4C, bit_p); wait_cyc(1);
            br(8'h40, rd); check("R5 cleared", rd, 0);
            check("R5 irq low", {31'b0, irq}, 0);
          end
        end
      end
    end

    // R5 selective clear
    pins = 0; wait_cyc(3);
    bw(8'h38, 32'hFFFF_FFFF); bw(8'h3C, 32'hFFFF_FFFF); bw(8'h30, 32'hFFFF_FFFF);
    bw(8'h4C, 32'hFFFF_FFFF);
    pins = 32'h0010_0208; wait_cyc(4);
    br(8'h40, rd); check("R5 three latched", rd, 32'h0010_0208);
    bw(8'h4C, 32'h0000_0200); wait_cyc(1);
    br(8'h40, rd); check("R5 one cleared", rd, 32'h0010_0008);

    // R8 mask
    bw(8'h34, 32'h0010_0008); wait_cyc(1);
    check("R8 masked irq", {31'b0, irq}, 0);
    br(8'h40, rd); check("R8 status unmasked view", rd, 32'h0010_0008);
    bw(8'h34, 32'h0000_0008); wait_cyc(1);
    check("R8 partial mask irq", {31'b0, irq}, 1);
    bw(8'h34, 32'hFFFF_FFFF); wait_cyc(1);
    check("R8 full mask irq", {31'b0, irq}, 0);
    br(8'h30, rd); check("R8 enable kept", rd, 32'hFFFF_FFFF);
    bw(8'h34, 0);
    bw(8'h4C, 32'hFFFF_FFFF); wait_cyc(1);
    br(8'h40, rd); check("R5 all cleared", rd, 0);

    // R6 clear write has no effect on level status
    bw(8'h38, 0); wait_cyc(1);
    br(8'h40, rd); check("R6 level status", rd, 32'h0010_0208);
    bw(8'h4C, 32'hFFFF_FFFF); wait_cyc(1);
    br(8'h40, rd); check("R6 clear ignored", rd, 32'h0010_0208);

    // R7 enable gates detection
    bw(8'h30, 0); wait_cyc(1);
    br(8'h40, rd); check("R7 level disabled", rd, 0);
    bw(8'h38, 32'hFFFF_FFFF); pins = 0; wait_cyc(3);
    pins = 32'hFFFF_FFFF; wait_cyc(4);
    br(8'h40, rd); check("R7 edge disabled", rd, 0);
    check("R7 irq", {31'b0, irq}, 0);

    // R11 software both-edge on pin 7
    pins = 0; wait_cyc(3);
    bw(8'h30, 32'h80); bw(8'h3C, 32'h80); bw(8'h4C, 32'hFFFF_FFFF);
    pins[7] = 1'b1; wait_cyc(4);
    br(8'h40, rd); check("R11 rising", rd, 32'h80);
    bw(8'h3C, 0); bw(8'h4C, 32'h80); wait_cyc(2);
    br(8'h40, rd); check("R11 no false edge on flip", rd, 0);
    pins[7] = 1'b0; wait_cyc(4);
    br(8'h40, rd); check("R11 falling", rd, 32'h80);
    bw(8'h4C, 32'hFFFF_FFFF);

    // R9 debounce on pin 5, rising edge
    pins = 0; wait_cyc(3);
    bw(8'h48, 32'h20); bw(8'h30, 32'h20); bw(8'h3C, 32'h20); bw(8'h4C, 32'hFFFF_FFFF);
    pins[5] = 1'b1; wait_cyc(4);
    strobe(); strobe(); strobe();
    br(8'h50, rd); check("R9 three strobes not enough", rd & 32'h20, 0);
    pins[5] = 1'b0; wait_cyc(4);
    strobe(); strobe(); strobe(); strobe();
    br(8'h40, rd); check("R9 short pulse dropped", rd, 0);
    pins[5] = 1'b1; wait_cyc(4);
    strobe(); strobe(); strobe();
    br(8'h40, rd); check("R9 still filtered", rd, 0);
    strobe(); wait_cyc(2);
    br(8'h50, rd); check("R9 accepted on fourth", rd & 32'h20, 32'h20);
    br(8'h40, rd); check("R9 edge after filter", rd, 32'h20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule